// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Break-Before-Make Direction Switching

This block drives the pad control signals for several banks of general-purpose pins. Each bank holds a direction register and a data register. For an input pin, the data register selects the pull-up. For an output pin, it gives the driven level. Pad inputs go through a synchronizer before software can read them. Every pin's output enable, output level and pull-up request is computed from these registers. Three override pairs let an alternate function take over any of those signals. Each override pair is an enable and a value.

Two controls shape the pad behaviour. Pull-ups can be disabled across the whole block, or for a single bank. A bank can also run in break-before-make mode. In that mode, a pin switched from input to output stays fully released for one clock before it starts driving. This guarantees that the weak pull-up and the strong driver are never both active in the same cycle. A small register bus gives access to everything: address, 8-bit write data, write strobe and combinational read data.

Top module: `gpio_bbm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. With no override active, all output enables, output levels and pull-up requests are 0.
- R2: Without overrides, a pin requests its pull-up only when its direction bit is 0 and its data bit is 1, and no pull-up disable applies to its bank.
- R3: Bit 0 of the global control register (address 13) disables every pull-up in every bank while it is 1.
- R4: Bit p (p = 0..3) of the bank control register (address 12) disables the pull-ups of bank p only. The disable that takes effect is the OR of this bit and the global bit.
- R5: Bit 4+p of the bank control register enables break-before-make for bank p. A direction write that moves a pin from 0 to 1 then keeps that pin's output enable, output level and pull-up at 0 for the cycle after the write. Output enable and output level then assert together on the following cycle.
- R6: With break-before-make off, a direction bit written to 1 drives on the cycle after the write. A pin written from output to input is released on the cycle after the write, whether or not break-before-make is on.
- R7: When a pin's pull-up, direction or output-level override enable is 1, the matching override value replaces the register-derived pull-up request, output enable or output level.
- R8: The input register of a bank returns the pad levels through two flip-flops. A pad change made before clock edge k becomes readable after edge k+1.
- R9: Register map: bank p has its direction register at 3p, its data register at 3p+1 and its read-only input register at 3p+2. Direction, data and both control registers read back the written values. Writes to input registers or to unused addresses (14, 15) change nothing, and unused addresses read 0.
- R10: Without an output-level override, a pin's output level is its data bit while the pin is actively driven, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 32 | Pad input levels, bank p at bits 8p+7:8p |
| pad_oe | output | 32 | Output enable per pin |
| pad_out | output | 32 | Output level per pin |
| pad_pu | output | 32 | Pull-up request per pin |
| ovr_pu_en | input | 32 | Pull-up override enable per pin |
| ovr_pu_val | input | 32 | Pull-up override value per pin |
| ovr_dir_en | input | 32 | Output-enable override enable per pin |
| ovr_dir_val | input | 32 | Output-enable override value per pin |
| ovr_out_en | input | 32 | Output-level override enable per pin |
| ovr_out_val | input | 32 | Output-level override value per pin |

## Verification
The hardest state to reach is the single released cycle of break-before-make. It exists only when a bank has the mode enabled and a direction write sets bits that were previously 0. Bits that were already 1 must keep driving through that same cycle. The stimulus first leaves some pins of a bank as outputs and others as inputs, then writes all ones to the direction register. Directed checks on the two cycles after the write cover this case. A randomized phase follows, mixing writes to every address with random overrides, so released cycles also occur next to pull-up disables and reverse transitions.

// File: rtl/gpio_pkg.sv
// Package gpio_pkg
// Shared constants for the GPIO controller: the number of registers per bank
// and the offset of each register within its bank window.
// Assumes the bus data width equals the bank width.
package gpio_pkg;

    localparam int REGS_PER_BANK = 3;

    typedef enum int {
        OFS_DIR  = 0,
        OFS_DATA = 1,
        OFS_IN   = 2
    } bank_ofs_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Multi-stage synchronizer that brings asynchronous pad levels into the
// clock domain. The output lags the input by STAGES clock edges.
// Assumes STAGES >= 2 and that reset clears every stage.
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the pad levels one stage further on every clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regbank.sv
// Module gpio_regbank
// Address decoder, shared control registers and read multiplexer.
// Bank p owns addresses 3p..3p+2. Bank control sits just above the bank
// windows: low NP bits hold per-bank pull-up disables, the next NP bits hold
// per-bank break-before-make enables. The global control register follows it.
// Assumes W >= 2*NP and 2^AW > 3*NP+1.
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int NP = 4,
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    input  logic            we,
    output logic [W-1:0]    rdata,
    output logic [NP-1:0]   wr_dir,
    output logic [NP-1:0]   wr_data,
    output logic [NP-1:0]   bbm_en,
    output logic [NP-1:0]   pud_bank,
    output logic            pud_glb,
    input  logic [NP*W-1:0] dir_all,
    input  logic [NP*W-1:0] data_all,
    input  logic [NP*W-1:0] in_all
);

    localparam logic [AW-1:0] CTRL_ADDR = AW'(NP * REGS_PER_BANK);
    localparam logic [AW-1:0] GLB_ADDR  = AW'(NP * REGS_PER_BANK + 1);
    localparam int            CTRL_W    = 2 * NP;

    logic [CTRL_W-1:0] ctrl_q;
    logic              glb_q;

    // Decode the bank-local write strobes for direction and data registers.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            wr_dir[p]  = we && (addr == AW'(p * REGS_PER_BANK + int'(OFS_DIR)));
            wr_data[p] = we && (addr == AW'(p * REGS_PER_BANK + int'(OFS_DATA)));
        end
    end

    // Hold the bank control and global control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            glb_q  <= 1'b0;
        end else if (we) begin
            if (addr == CTRL_ADDR) ctrl_q <= wdata[CTRL_W-1:0];
            if (addr == GLB_ADDR)  glb_q  <= wdata[0];
        end
    end

    assign pud_bank = ctrl_q[NP-1:0];
    assign bbm_en   = ctrl_q[CTRL_W-1:NP];
    assign pud_glb  = glb_q;

    // Select the read data for the addressed register; unmapped reads give 0.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NP; p++) begin
            if (addr == AW'(p * REGS_PER_BANK + int'(OFS_DIR)))  rdata = dir_all[p*W +: W];
            if (addr == AW'(p * REGS_PER_BANK + int'(OFS_DATA))) rdata = data_all[p*W +: W];
            if (addr == AW'(p * REGS_PER_BANK + int'(OFS_IN)))   rdata = in_all[p*W +: W];
        end
        if (addr == CTRL_ADDR) rdata[CTRL_W-1:0] = ctrl_q;
        if (addr == GLB_ADDR)  rdata[0]          = glb_q;
    end

endmodule

// File: rtl/gpio_bank.sv
// Module gpio_bank
// One bank of pins: direction and data registers, the break-before-make
// release flags, the input synchronizer and the per-pin pad logic with
// alternate-function overrides.
// Assumes bbm_en is stable in the cycle in which a direction write happens
// (the register bank accepts only one write per cycle).
module gpio_bank #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         wr_dir,
    input  logic         wr_data,
    input  logic         bbm_en,
    input  logic         pud_bank,
    input  logic         pud_glb,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] ovr_pu_en,
    input  logic [W-1:0] ovr_pu_val,
    input  logic [W-1:0] ovr_dir_en,
    input  logic [W-1:0] ovr_dir_val,
    input  logic [W-1:0] ovr_out_en,
    input  logic [W-1:0] ovr_out_val,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q,
    output logic [W-1:0] hold_q,
    output logic [W-1:0] in_sync,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);

    logic [W-1:0] dir_eff;
    logic [W-1:0] pu_reg;
    logic [W-1:0] out_reg;
    logic         pud_eff;

    // Update the bank registers and arm a one-cycle release on rising direction bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
            hold_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata;
            if (wr_data) data_q <= wdata;
            hold_q <= (wr_dir && bbm_en) ? (wdata & ~dir_q) : '0;
        end
    end

    gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // Derive the register-side pad requests for every pin of the bank.
    always_comb begin
        pud_eff = pud_bank | pud_glb;
        dir_eff = dir_q & ~hold_q;
        pu_reg  = ~dir_q & ~hold_q & data_q & {W{~pud_eff}};
        out_reg = data_q & dir_eff;
    end

    // Apply the alternate-function overrides pin by pin.
    always_comb begin
        pad_oe  = (ovr_dir_en & ovr_dir_val) | (~ovr_dir_en & dir_eff);
        pad_out = (ovr_out_en & ovr_out_val) | (~ovr_out_en & out_reg);
        pad_pu  = (ovr_pu_en  & ovr_pu_val)  | (~ovr_pu_en  & pu_reg);
    end

endmodule

// File: rtl/gpio_bbm_ctrl.sv
// Module gpio_bbm_ctrl
// Top level of the multi-bank GPIO controller. Instantiates the register
// bank and one gpio_bank per bank; pin vectors are flat, bank p at
// bits p*PORT_W +: PORT_W.
// Assumes PORT_W >= 2*NUM_PORTS so the bank control fits one data word.
module gpio_bbm_ctrl #(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_we,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_pu,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_pu_en,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_pu_val,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_dir_en,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_dir_val,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_out_en,
    input  logic [NUM_PORTS*PORT_W-1:0] ovr_out_val
);

    localparam int TOTAL_W = NUM_PORTS * PORT_W;

    logic [NUM_PORTS-1:0] wr_dir;
    logic [NUM_PORTS-1:0] wr_data;
    logic [NUM_PORTS-1:0] bbm_en;
    logic [NUM_PORTS-1:0] pud_bank;
    logic                 pud_glb;
    logic [TOTAL_W-1:0]   dir_all;
    logic [TOTAL_W-1:0]   data_all;
    logic [TOTAL_W-1:0]   hold_all;
    logic [TOTAL_W-1:0]   in_all;

    gpio_regbank #(.NP(NUM_PORTS), .W(PORT_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .rdata    (bus_rdata),
        .wr_dir   (wr_dir),
        .wr_data  (wr_data),
        .bbm_en   (bbm_en),
        .pud_bank (pud_bank),
        .pud_glb  (pud_glb),
        .dir_all  (dir_all),
        .data_all (data_all),
        .in_all   (in_all)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
        gpio_bank #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wdata       (bus_wdata),
            .wr_dir      (wr_dir[p]),
            .wr_data     (wr_data[p]),
            .bbm_en      (bbm_en[p]),
            .pud_bank    (pud_bank[p]),
            .pud_glb     (pud_glb),
            .pad_in      (pad_in[p*PORT_W +: PORT_W]),
            .ovr_pu_en   (ovr_pu_en[p*PORT_W +: PORT_W]),
            .ovr_pu_val  (ovr_pu_val[p*PORT_W +: PORT_W]),
            .ovr_dir_en  (ovr_dir_en[p*PORT_W +: PORT_W]),
            .ovr_dir_val (ovr_dir_val[p*PORT_W +: PORT_W]),
            .ovr_out_en  (ovr_out_en[p*PORT_W +: PORT_W]),
            .ovr_out_val (ovr_out_val[p*PORT_W +: PORT_W]),
            .dir_q       (dir_all[p*PORT_W +: PORT_W]),
            .data_q      (data_all[p*PORT_W +: PORT_W]),
            .hold_q      (hold_all[p*PORT_W +: PORT_W]),
            .in_sync     (in_all[p*PORT_W +: PORT_W]),
            .pad_oe      (pad_oe[p*PORT_W +: PORT_W]),
            .pad_out     (pad_out[p*PORT_W +: PORT_W]),
            .pad_pu      (pad_pu[p*PORT_W +: PORT_W])
        );
    end

endmodule

// File: rtl/gpio_bbm_ctrl_chk.sv
// Module gpio_bbm_ctrl_chk
// Property checker for gpio_bbm_ctrl, attached through bind. It watches the
// pad outputs against the bank registers, the release flags and the
// pull-up controls.
module gpio_bbm_ctrl_chk #(
    parameter int NP = 4,
    parameter int W  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP*W-1:0] pad_oe,
    input logic [NP*W-1:0] pad_out,
    input logic [NP*W-1:0] pad_pu,
    input logic [NP*W-1:0] ovr_pu_en,
    input logic [NP*W-1:0] ovr_dir_en,
    input logic [NP*W-1:0] ovr_out_en,
    input logic [NP*W-1:0] dir_all,
    input logic [NP*W-1:0] hold_all,
    input logic [NP-1:0]   bbm_en,
    input logic            pud_glb
);

    // R1: after a reset edge, nothing drives or pulls unless an override says so.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (((pad_oe & ~ovr_dir_en) == '0) && ((pad_pu & ~ovr_pu_en) == '0)));

    // R2: no register-derived pull-up on a pin configured as output.
    assert_pu_only_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & ~ovr_pu_en & dir_all) == '0));

    // R3: the global disable removes every register-derived pull-up.
    assert_glb_pud_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pud_glb |-> ((pad_pu & ~ovr_pu_en) == '0));

    // R5: a pin in its released cycle neither drives nor pulls.
    assert_bbm_tristate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((hold_all & ~ovr_dir_en) & pad_oe) == '0) &&
        (((hold_all & ~ovr_pu_en) & pad_pu) == '0) &&
        (((hold_all & ~ovr_out_en) & pad_out) == '0));

    // R5: a released cycle never lasts longer than one clock for any pin.
    assert_bbm_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_all) |=> ((hold_all & $past(hold_all)) == '0));

    for (genvar p = 0; p < NP; p++) begin : g_bank_chk
        // R6: a bank without break-before-make never has a released pin.
        assert_no_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !bbm_en[p] |-> (hold_all[p*W +: W] == '0));
    end

endmodule

bind gpio_bbm_ctrl gpio_bbm_ctrl_chk #(.NP(NUM_PORTS), .W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .ovr_pu_en  (ovr_pu_en),
    .ovr_dir_en (ovr_dir_en),
    .ovr_out_en (ovr_out_en),
    .dir_all    (dir_all),
    .hold_all   (hold_all),
    .bbm_en     (bbm_en),
    .pud_glb    (pud_glb)
);

// File: tb/tb_gpio_bbm_ctrl.sv
// Bench for gpio_bbm_ctrl: behavioural reference model stepped on every
// clock edge, compared at the falling edge, plus directed checks.
module tb_gpio_bbm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int W  = 8;
    localparam int TW = NP * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_rdata;
    logic [TW-1:0] pad_in = '0;
    logic [TW-1:0] pad_oe, pad_out, pad_pu;
    logic [TW-1:0] ovr_pu_en = '0, ovr_pu_val = '0;
    logic [TW-1:0] ovr_dir_en = '0, ovr_dir_val = '0;
    logic [TW-1:0] ovr_out_en = '0, ovr_out_val = '0;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_dir [NP];
    logic [7:0] m_prt [NP];
    logic [7:0] m_hold[NP];
    logic [7:0] m_s1  [NP];
    logic [7:0] m_s2  [NP];
    logic [3:0] m_pudp, m_bbm;
    logic       m_gpud;

    gpio_bbm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
        .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
        .ovr_out_en(ovr_out_en), .ovr_out_val(ovr_out_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_dir[p] = 0; m_prt[p] = 0; m_hold[p] = 0; m_s1[p] = 0; m_s2[p] = 0;
            end
            m_pudp = 0; m_bbm = 0; m_gpud = 0;
        end else begin
            logic [7:0] nh [NP];
            for (int p = 0; p < NP; p++) begin
                nh[p]   = 0;
                m_s2[p] = m_s1[p];
                m_s1[p] = pad_in[p*W +: W];
            end
            if (bus_we) begin
                if (bus_addr < 12) begin
                    int p = int'(bus_addr) / 3;
                    if (int'(bus_addr) % 3 == 0) begin
                        if (m_bbm[p]) nh[p] = bus_wdata & ~m_dir[p];
                        m_dir[p] = bus_wdata;
                    end else if (int'(bus_addr) % 3 == 1) begin
                        m_prt[p] = bus_wdata;
                    end
                end else if (bus_addr == 12) begin
                    {m_bbm, m_pudp} = bus_wdata;
                end else if (bus_addr == 13) begin
                    m_gpud = bus_wdata[0];
                end
            end
            for (int p = 0; p < NP; p++) m_hold[p] = nh[p];
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a < 12) begin
            int p = int'(a) / 3;
            case (int'(a) % 3)
                0: return m_dir[p];
                1: return m_prt[p];
                default: return m_s2[p];
            endcase
        end
        if (a == 12) return {m_bbm, m_pudp};
        if (a == 13) return {7'b0, m_gpud};
        return 8'h00;
    endfunction

    task automatic compare_all();
        logic [TW-1:0] e_oe, e_out, e_pu;
        for (int p = 0; p < NP; p++) begin
            logic [7:0] de, pu, ov;
            de = m_dir[p] & ~m_hold[p];
            pu = (m_pudp[p] || m_gpud) ? 8'h00 : (~m_dir[p] & ~m_hold[p] & m_prt[p]);
            ov = m_prt[p] & de;
            for (int b = 0; b < W; b++) begin
                int i = p*W + b;
                e_oe[i]  = ovr_dir_en[i] ? ovr_dir_val[i] : de[b];
                e_out[i] = ovr_out_en[i] ? ovr_out_val[i] : ov[b];
                e_pu[i]  = ovr_pu_en[i]  ? ovr_pu_val[i]  : pu[b];
            end
        end
        chk(pad_oe  === e_oe,  {cur_req, " pad_oe"},  pad_oe,  e_oe);
        chk(pad_out === e_out, {cur_req, " pad_out"}, pad_out, e_out);
        chk(pad_pu  === e_pu,  {cur_req, " pad_pu"},  pad_pu,  e_pu);
        chk(bus_rdata === exp_read(bus_addr), {cur_req, " rdata"}, {24'h0, bus_rdata}, {24'h0, exp_read(bus_addr)});
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        logic [7:0] r;
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        step();
        for (int a = 0; a < 14; a++) begin
            rd(4'(a), r);
            chk(r == 8'h00, "R1 register reset value", {24'h0, r}, 32'h0);
        end
        chk(pad_oe == '0 && pad_pu == '0 && pad_out == '0, "R1 pads quiet", pad_oe | pad_pu, 32'h0);

        // R9: register map readback and ignored writes
        cur_req = "R9";
        wr(4'd3, 8'h11); wr(4'd4, 8'h22); wr(4'd12, 8'h00); wr(4'd13, 8'h00);
        rd(4'd3, r); chk(r == 8'h11, "R9 bank1 direction readback", {24'h0, r}, 32'h11);
        rd(4'd4, r); chk(r == 8'h22, "R9 bank1 data readback", {24'h0, r}, 32'h22);
        pad_in[7:0] = 8'h3C;
        step(); step();
        wr(4'd2, 8'hFF);
        rd(4'd2, r); chk(r == 8'h3C, "R9 input register write ignored", {24'h0, r}, 32'h3C);
        wr(4'd14, 8'hFF); wr(4'd15, 8'hFF);
        rd(4'd14, r); chk(r == 8'h00, "R9 unused address reads 0", {24'h0, r}, 32'h0);
        rd(4'd3, r); chk(r == 8'h11, "R9 unused write leaves registers", {24'h0, r}, 32'h11);
        wr(4'd3, 8'h00); wr(4'd4, 8'h00);

        // R2: pull-up only on inputs with data bit 1
        cur_req = "R2";
        wr(4'd1, 8'hF0); wr(4'd0, 8'h3C);
        chk(pad_pu[7:0] == 8'hC0, "R2 pull-up selection", {24'h0, pad_pu[7:0]}, 32'hC0);

        // R4: per-bank disable affects only its bank
        cur_req = "R4";
        wr(4'd4, 8'hFF);
        chk(pad_pu[15:8] == 8'hFF, "R4 bank1 pull-ups before disable", {24'h0, pad_pu[15:8]}, 32'hFF);
        wr(4'd12, 8'h02);
        chk(pad_pu[15:8] == 8'h00, "R4 bank1 disabled", {24'h0, pad_pu[15:8]}, 32'h0);
        chk(pad_pu[7:0] == 8'hC0, "R4 bank0 untouched", {24'h0, pad_pu[7:0]}, 32'hC0);
        wr(4'd12, 8'h00);

        // R3: global disable
        cur_req = "R3";
        wr(4'd13, 8'h01);
        chk(pad_pu == '0, "R3 global disable", pad_pu, 32'h0);
        wr(4'd13, 8'h00);
        chk(pad_pu[7:0] == 8'hC0, "R3 global disable released", {24'h0, pad_pu[7:0]}, 32'hC0);

        // R5: break-before-make gap on bank0
        cur_req = "R5";
        wr(4'd12, 8'h10);
        wr(4'd0, 8'hFF);
        chk(pad_oe[7:0] == 8'h3C, "R5 released cycle oe", {24'h0, pad_oe[7:0]}, 32'h3C);
        chk(pad_out[7:0] == 8'h30, "R5 released cycle out", {24'h0, pad_out[7:0]}, 32'h30);
        chk(pad_pu[7:0] == 8'h00, "R5 released cycle pull-up", {24'h0, pad_pu[7:0]}, 32'h0);
        step();
        chk(pad_oe[7:0] == 8'hFF, "R5 drive after gap", {24'h0, pad_oe[7:0]}, 32'hFF);
        chk(pad_out[7:0] == 8'hF0, "R5 out after gap", {24'h0, pad_out[7:0]}, 32'hF0);

        // R6: no gap without the mode; output-to-input immediate with the mode
        cur_req = "R6";
        wr(4'd3, 8'h0F);
        chk(pad_oe[15:8] == 8'h0F, "R6 immediate drive", {24'h0, pad_oe[15:8]}, 32'h0F);
        wr(4'd0, 8'h00);
        chk(pad_oe[7:0] == 8'h00, "R6 immediate release", {24'h0, pad_oe[7:0]}, 32'h0);

        // R10: output level gated by drive
        cur_req = "R10";
        wr(4'd7, 8'hAA);
        chk(pad_out[23:16] == 8'h00, "R10 out low while input", {24'h0, pad_out[23:16]}, 32'h0);
        wr(4'd6, 8'h0F);
        chk(pad_out[23:16] == 8'h0A, "R10 out follows data", {24'h0, pad_out[23:16]}, 32'h0A);

        // R7: overrides
        cur_req = "R7";
        ovr_dir_en[23:16] = 8'hFF; ovr_dir_val[23:16] = 8'h55;
        ovr_out_en[23:16] = 8'hF0; ovr_out_val[23:16] = 8'h30;
        ovr_pu_en[31:24]  = 8'h0F; ovr_pu_val[31:24]  = 8'h05;
        step();
        chk(pad_oe[23:16] == 8'h55, "R7 direction override", {24'h0, pad_oe[23:16]}, 32'h55);
        chk(pad_out[23:16] == 8'h3A, "R7 out override", {24'h0, pad_out[23:16]}, 32'h3A);
        chk(pad_pu[31:24] == 8'h05, "R7 pull-up override", {24'h0, pad_pu[31:24]}, 32'h05);
        ovr_dir_en = '0; ovr_out_en = '0; ovr_pu_en = '0;

        // R8: two-stage input synchronization
        cur_req = "R8";
        pad_in[31:24] = 8'h5A;
        step();
        rd(4'd11, r); chk(r == 8'h00, "R8 one edge later still old", {24'h0, r}, 32'h0);
        step();
        rd(4'd11, r); chk(r == 8'h5A, "R8 two edges later new", {24'h0, r}, 32'h5A);

        // R2/R4/R5/R7 randomized mix
        cur_req = "R2/R3/R4/R5/R6/R7/R9 random";
        for (int n = 0; n < 600; n++) begin
            bus_we      = ($urandom % 2) == 0;
            bus_addr    = 4'($urandom);
            bus_wdata   = 8'($urandom);
            pad_in      = $urandom;
            ovr_dir_en  = $urandom & $urandom & $urandom;
            ovr_dir_val = $urandom;
            ovr_out_en  = $urandom & $urandom & $urandom;
            ovr_out_val = $urandom;
            ovr_pu_en   = $urandom & $urandom & $urandom;
            ovr_pu_val  = $urandom;
            step();
        end
        bus_we = 1'b0;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule